// File: doc/BRIEF.md
# Four-Lane Serializer with Forwarded Clock

This block is the digital back end of a serial transmitter. Each parallel word has four lanes. A word comes either from a built-in 7-bit pseudo-random generator or from an external 4-bit input. The lanes are held in staggered registers, so each lane only changes away from the slot in which it is picked. A two-level tree of registered two-to-one selectors then sends the word out one bit per cycle of the bit-rate clock.

A forwarded clock leaves alongside the data. It passes through the same two register levels as the data, so its edges keep a fixed relation to the bit slots. A mode input picks its rate: one sixteenth of the bit rate, or half the bit rate. At half the bit rate it looks like an alternating 0-1 data pattern.

Timing is counted from reset release. The first cycle after release is slot 0, and the slot advances by one each cycle, modulo 4. A word is captured on the edge that ends slot 3.

Top module: `lane_serializer_tx`

## Requirements
- R1: Each captured word leaves on `serialOut` as four consecutive bits, lane 0 first, then lane 1, lane 2 and lane 3. There is one bit per clock cycle and no gap between words.
- R2: The lane-0 bit of a word captured on a given edge is visible in the cycle after the 6th edge that follows the capture edge. Lanes 1 to 3 follow in the next three cycles. All bits before the first captured word are 0.
- R3: The register holding lane k updates only on the edge that ends slot k. It is therefore constant through the whole slot in which the selector tree samples it.
- R4: In pattern mode, the generator is a 7-bit register with feedback bit6 XOR bit5 (polynomial x^7 + x^6 + 1). Each step shifts left and inserts the feedback at bit 0. The generator takes four steps per word, and lane k of the word is the feedback bit of step k.
- R5: Reset loads the generator with all ones. It never enters the all-zero state. Its serial sequence repeats every 127 bits, with 64 ones in each period.
- R6: `useExt` and `extLanes` are sampled only on the edge that ends slot 3. When `useExt` is 1, lane k of that word is `extLanes[k]`. Changes at any other edge have no effect on the output. The generator advances in both cases.
- R7: With `clkMode` = 0, `fwdClk` has a period of 16 cycles, high for 8 and low for 8.
- R8: With `clkMode` = 1, `fwdClk` toggles every cycle.
- R9: `fwdClk` in cycle n is bit 0 (mode 1) or bit 3 (mode 0) of the cycle count n-2, using the mode value at that earlier edge. In steady mode 1, `fwdClk` is high exactly while lanes 1 and 3 are on `serialOut`. In steady mode 0, it rises only at the start of a lane-0 bit.
- R10: While reset is asserted, `serialOut` and `fwdClk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; four cycles form one word period |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkMode | input | 1 | Forwarded clock rate: 0 = bit rate / 16, 1 = bit rate / 2 |
| useExt | input | 1 | 1 = take lanes from `extLanes`, 0 = take the internal pattern |
| extLanes | input | 4 | External lane data, bit k = lane k |
| serialOut | output | 1 | Serialized data bit |
| fwdClk | output | 1 | Forwarded clock, latency-matched to the data |

## Verification
A wrong slot count or a wrongly staggered lane register shows within one word period. It appears as a bit in the wrong position, or a bit taken from the neighbouring word, about six to nine cycles after the capture edge. A generator fault shows on the first pattern word, and a short sequence period shows after 127 bits. A clock-path latency that differs from the data path shifts every `fwdClk` edge against the lane positions, and this is visible within two cycles of reset release or of a mode change.

// File: rtl/txser_pkg.sv
`timescale 1ns/1ps
package txser_pkg;
  localparam int LANE_CNT = 4;
  localparam int SEL_W    = $clog2(LANE_CNT);

  typedef struct packed {
    logic [SEL_W-1:0]    slot;
    logic                wordLoad;
    logic [LANE_CNT-1:0] laneLoad;
    logic                fwdRaw;
    logic                fastMode;
  } txStrobe_t;
endpackage

// File: rtl/txser_prbs.sv
`timescale 1ns/1ps
module txser_prbs #(
  parameter int STATE_W = 7,
  parameter int TAP_HI  = 7,
  parameter int TAP_LO  = 6,
  parameter int WORD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [WORD_W-1:0] patWord
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stateNext;

  always_comb begin
    logic [STATE_W-1:0] walk;
    logic fb;
    walk    = stateQ;
    patWord = '0;
    for (int i = 0; i < WORD_W; i++) begin
      fb         = walk[TAP_HI-1] ^ walk[TAP_LO-1];
      patWord[i] = fb;
      walk       = {walk[STATE_W-2:0], fb};
    end
    stateNext = walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stateQ <= '1;
    else if (advance) stateQ <= stateNext;
  end

  // Generator must never reach the lock-up state (R5)
  p_no_lockup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stateQ != '0);
endmodule

// File: rtl/txser_ctrl.sv
`timescale 1ns/1ps
module txser_ctrl
  import txser_pkg::*;
#(
  parameter int SLOW_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clkMode,
  output txStrobe_t strb
);
  localparam int CNT_W = (SLOW_LOG2 > SEL_W) ? SLOW_LOG2 : SEL_W;

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else        divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strb.slot     = divCnt[SEL_W-1:0];
    strb.wordLoad = (divCnt[SEL_W-1:0] == SEL_W'(LANE_CNT-1));
    for (int k = 0; k < LANE_CNT; k++)
      strb.laneLoad[k] = (divCnt[SEL_W-1:0] == SEL_W'(k));
    strb.fwdRaw   = clkMode ? divCnt[0] : divCnt[SLOW_LOG2-1];
    strb.fastMode = clkMode;
  end
endmodule

// File: rtl/txser_datapath.sv
`timescale 1ns/1ps
module txser_datapath
  import txser_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  txStrobe_t           strb,
  input  logic                useExt,
  input  logic [LANE_CNT-1:0] extLanes,
  input  logic [LANE_CNT-1:0] patWord,
  output logic                serialOut,
  output logic                fwdClk
);
  localparam int HALF = LANE_CNT / 2;

  logic [LANE_CNT-1:0] wordQ;
  logic [LANE_CNT-1:0] laneQ;
  logic [HALF-1:0]     levelOneQ;
  logic                selLowQ;
  logic                fwdStageQ;
  logic                fastQ1, fastQ2;
  logic [1:0]          ageQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wordQ <= '0;
    else if (strb.wordLoad) wordQ <= useExt ? extLanes : patWord;
  end

  // staggered lane holding registers
  for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                laneQ[k] <= 1'b0;
      else if (strb.laneLoad[k]) laneQ[k] <= wordQ[k];
    end

    // lane k moves only on the edge closing slot k (R3)
    p_lane_stagger_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (laneQ[k] != $past(laneQ[k])) |-> ($past(strb.slot) == SEL_W'(k)));
  end

  // selector tree level one: pairs lane g with lane g+HALF
  for (genvar g = 0; g < HALF; g++) begin : g_level_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) levelOneQ[g] <= 1'b0;
      else        levelOneQ[g] <= strb.slot[SEL_W-1] ? laneQ[g+HALF] : laneQ[g];
    end
  end

  // selector tree level two and matched clock path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selLowQ   <= 1'b0;
      serialOut <= 1'b0;
      fwdStageQ <= 1'b0;
      fwdClk    <= 1'b0;
      fastQ1    <= 1'b0;
      fastQ2    <= 1'b0;
      ageQ      <= '0;
    end else begin
      selLowQ   <= strb.slot[0];
      serialOut <= selLowQ ? levelOneQ[1] : levelOneQ[0];
      fwdStageQ <= strb.fwdRaw;
      fwdClk    <= fwdStageQ;
      fastQ1    <= strb.fastMode;
      fastQ2    <= fastQ1;
      if (ageQ != 2'd3) ageQ <= ageQ + 2'd1;
    end
  end

  // external lanes land in the word register when selected (R6)
  p_ext_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb.wordLoad) && $past(useExt)) |-> (wordQ == $past(extLanes)));

  // word register holds between word boundaries (R6)
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wordQ != $past(wordQ)) |-> $past(strb.wordLoad));

  // half-rate forwarded clock toggles every cycle (R8)
  p_fast_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ageQ == 2'd3 && fastQ2 && $past(fastQ2)) |-> (fwdClk != $past(fwdClk)));
endmodule

// File: rtl/lane_serializer_tx.sv
`timescale 1ns/1ps
module lane_serializer_tx
  import txser_pkg::*;
#(
  parameter int PRBS_W    = 7,
  parameter int TAP_HI    = 7,
  parameter int TAP_LO    = 6,
  parameter int SLOW_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clkMode,
  input  logic                useExt,
  input  logic [LANE_CNT-1:0] extLanes,
  output logic                serialOut,
  output logic                fwdClk
);
  txStrobe_t           strb;
  logic [LANE_CNT-1:0] patWord;

  txser_ctrl #(.SLOW_LOG2(SLOW_LOG2)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clkMode (clkMode),
    .strb    (strb)
  );

  txser_prbs #(
    .STATE_W (PRBS_W),
    .TAP_HI  (TAP_HI),
    .TAP_LO  (TAP_LO),
    .WORD_W  (LANE_CNT)
  ) i_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (strb.wordLoad),
    .patWord (patWord)
  );

  txser_datapath i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .useExt    (useExt),
    .extLanes  (extLanes),
    .patWord   (patWord),
    .serialOut (serialOut),
    .fwdClk    (fwdClk)
  );
endmodule

// File: tb/test_lane_serializer_tx.sv
`timescale 1ns/1ps
module test_lane_serializer_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clkMode;
  logic       useExt;
  logic [3:0] extLanes;
  logic       serialOut;
  logic       fwdClk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_serializer_tx i_lane_serializer_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clkMode   (clkMode),
    .useExt    (useExt),
    .extLanes  (extLanes),
    .serialOut (serialOut),
    .fwdClk    (fwdClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference state
  logic [6:0] genState;
  logic [3:0] wordQ[$];
  bit         extSrc[$];
  bit         serialLog[$];
  bit         pr1, pr2, prevFwd;
  int         stableCnt;
  bit         lastMode;

  function automatic logic [3:0] nextPattern();
    logic [3:0] w;
    for (int i = 0; i < 4; i++) begin
      logic fb;
      fb = genState[6] ^ genState[5];
      w[i] = fb;
      genState = {genState[5:0], fb};
    end
    return w;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finishRun();
    end
  end

  initial begin
    int e;
    rst_n = 1'b0; clkMode = 1'b0; useExt = 1'b0; extLanes = 4'h0;
    repeat (3) @(negedge clk);
    check(serialOut == 1'b0, "R10", serialOut, 0);
    check(fwdClk == 1'b0, "R10", fwdClk, 0);
    rst_n = 1'b1;
    genState = 7'h7f; pr1 = 0; pr2 = 0; prevFwd = 0; stableCnt = 0; lastMode = 0;
    e = 0;
    while (e < 1200) begin
      // ---- check outputs of cycle e ----
      begin
        bit expS;
        string req;
        int m;
        expS = 1'b0;
        req  = "R10";
        if (e >= 10) begin
          m    = e - 6;
          expS = wordQ[m/4 - 1][m%4];
          req  = (e < 14) ? "R2" : (extSrc[m/4 - 1] ? "R3,R6" : "R1,R4");
        end
        check(serialOut == expS, req, serialOut, expS);
        check(fwdClk == pr2, lastMode ? "R8,R9" : "R7,R9", fwdClk, pr2);
        if (stableCnt >= 3 && e >= 10) begin
          if (lastMode)
            check(fwdClk == ((e - 2) % 2), "R9", fwdClk, (e - 2) % 2);
          else if (!prevFwd && fwdClk)
            check(((e - 6) % 4) == 0, "R9", (e - 6) % 4, 0);
        end
        if (e >= 10 && e < 400) serialLog.push_back(serialOut);
        prevFwd = fwdClk;
      end
      // ---- drive inputs for the next edge ----
      begin
        bit newMode;
        newMode  = (e >= 400 && e < 900);
        useExt   = (e >= 700 && e < 1050);
        extLanes = 4'((e * 5 + 3) & 15);
        if (newMode == lastMode) stableCnt++; else stableCnt = 0;
        lastMode = newMode;
        clkMode  = newMode;
        pr2 = pr1;
        pr1 = newMode ? e[0] : e[3];
        if (e % 4 == 3) begin
          logic [3:0] pw;
          pw = nextPattern();
          wordQ.push_back(useExt ? extLanes : pw);
          extSrc.push_back(useExt);
        end
      end
      @(posedge clk);
      e++;
      @(negedge clk);
    end
    // ---- sequence period (R5) ----
    begin
      int ones;
      ones = 0;
      for (int i = 0; i < 127; i++) ones += serialLog[i];
      check(ones == 64, "R5", ones, 64);
      for (int i = 0; i + 127 < serialLog.size(); i += 17)
        check(serialLog[i] == serialLog[i + 127], "R5", serialLog[i + 127], serialLog[i]);
    end
    rst_n = 1'b0;
    #1;
    check(serialOut == 1'b0 && fwdClk == 1'b0, "R10", {serialOut, fwdClk}, 0);
    done = 1'b1;
    finishRun();
  end
endmodule